// File: doc/BRIEF.md
# Forward-Slice Replay and Validation Unit

After a value misprediction has been detected for a long-latency load, this unit replays the buffered forward slice of that load. It consumes the slice one entry at a time, in program order. Each entry carries the operation and registers, the immediate, the address the initial run used, the data the initial run saw, and the branch direction the initial run took. The seed load takes the corrected value, which is latched at the start pulse. Every other operand comes from live-in registers that were loaded beforehand, or from a register that an earlier entry of the replay wrote. When several slices overlap, the collection stage supplies them as one merged stream in program order, and the unit simply consumes that stream.

While the replay runs, the unit checks a sufficient safety condition. Every branch must resolve the same way it did in the initial run. A load whose address changed must be served by a store earlier in the same replay. A store whose address changed must not land on a location that the initial run read. If the whole stream passes, the `ok` flag rises. The unit then streams write-back requests for every register the replay wrote, then the replayed stores. If the check fails, the unit drains the rest of the stream and then streams the undo log in reverse, so that memory is restored before `done` is pulsed with `ok` low. The undo log records the first initial-run store to each location.

Streamed data uses valid/ready. The slice stream (`ins_*`) is accepted only while the replay runs, on a cycle where `ins_valid` and `ins_ready` are both high. On `wb_*` and `mw_*`, a request whose `*_ready` is low stays on the port unchanged until it is taken. Live-in loads, read-footprint loads and `start` are plain single-cycle pulses, given while the unit is idle.

Top module: `rsx_replay_unit`

## Requirements
- R1: After reset, `ins_ready`, `wb_valid`, `mw_valid`, `done` and `ok` are all low.
- R2: Entries are executed in arrival order, one per handshake. Operation codes: 0 add, 1 subtract (rs1-rs2), 2 add immediate, 3 seed (destination takes the corrected value), 4 load from rs1+imm, 5 store rs2 to rs1+imm, 6 branch-if-zero on rs1. Operands not written earlier in the replay come from the live-ins.
- R3: A branch entry whose replayed direction (rs1 equals zero) differs from its recorded direction makes the replay fail.
- R4: A load takes the value of the youngest earlier replayed store to its address. Failing that, if its address equals the recorded address, it takes the recorded data. Otherwise the replay fails; this covers a moved load that lands on a location the slice wrote in the initial run.
- R5: A store whose address differs from its recorded address fails the replay if the new address is in the read footprint.
- R6: Every store entry logs its recorded address and recorded old data into the undo log, unless that address is already logged. This happens even when the replay has already failed or that same store fails.
- R7: On success, `ok` rises first. Next comes one write-back for each register the replay wrote, in ascending index order. Then the replayed stores go out on `mw_*` in program order, and then `done` is pulsed.
- R8: On failure, there is no write-back. The undo log goes out on `mw_*` newest entry first, and then `done` is pulsed with `ok` low.
- R9: A request on `wb_*` or `mw_*` holds its payload while ready is low. `wb_valid` is never high while `ok` is low.
- R10: After a failure, the unit keeps accepting entries until the entry marked last. Those entries change no registers and no replayed stores.
- R11: `done` is high for exactly one cycle. `ok` holds its value until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| li_we | input | 1 | Live-in register load strobe |
| li_idx | input | RW | Live-in register index |
| li_val | input | DW | Live-in value |
| fp_we | input | 1 | Read-footprint address load strobe |
| fp_addr | input | AW | Address read by the initial run |
| start | input | 1 | Misprediction signalled: begin replay |
| fix_val | input | DW | Corrected seed value |
| ins_valid | input | 1 | Slice entry valid |
| ins_ready | output | 1 | Slice entry accepted |
| ins_op | input | 3 | Operation code |
| ins_rd | input | RW | Destination register |
| ins_rs1 | input | RW | First source register |
| ins_rs2 | input | RW | Second source register |
| ins_imm | input | DW | Immediate / address offset |
| ins_rec_addr | input | AW | Address used in the initial run |
| ins_rec_data | input | DW | Load data seen, or old value a store replaced |
| ins_rec_taken | input | 1 | Branch direction in the initial run |
| ins_last | input | 1 | Final entry of the stream |
| wb_valid | output | 1 | Register write-back request |
| wb_ready | input | 1 | Write-back taken |
| wb_idx | output | RW | Register index |
| wb_data | output | DW | Register value |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory write taken |
| mw_addr | output | AW | Memory address |
| mw_data | output | DW | Memory data |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Replay validated and merged |

## Verification
In one cycle, a single store entry can both open a new undo entry and fail the inhibiting-address check. That entry must still be logged, or its initial-run store could never be undone. The bench provokes this with a store that moves onto a footprint address as the final entry of a stream. It judges the result by `ok` staying low and by that store's recorded location and old data appearing on the memory write channel. A second overlap comes when a failing branch is followed by a further store: the failure and the later undo logging fall within the same drained stream, and the reversed undo order shows that both took effect.

// File: rtl/rsx_pkg.sv
package rsx_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_ADDI  = 3'd2,
    OP_SEED  = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5,
    OP_BRZ   = 3'd6,
    OP_NOP   = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_WB, ST_MW, ST_UNDO, ST_DONE
  } st_e;
endpackage

// File: rtl/rsx_regfile.sv
module rsx_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_mask,
  input  logic            li_we,
  input  logic [RW-1:0]   li_idx,
  input  logic [DW-1:0]   li_val,
  input  logic            ex_we,
  input  logic [RW-1:0]   ex_idx,
  input  logic [DW-1:0]   ex_val,
  input  logic [RW-1:0]   a_idx,
  input  logic [RW-1:0]   b_idx,
  input  logic [RW-1:0]   c_idx,
  output logic [DW-1:0]   a_val,
  output logic [DW-1:0]   b_val,
  output logic [DW-1:0]   c_val,
  output logic [NREG-1:0] wmask
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      wmask <= '0;
    end else begin
      if (li_we) regs_q[li_idx] <= li_val;
      if (ex_we) begin
        regs_q[ex_idx] <= ex_val;
        wmask[ex_idx]  <= 1'b1;
      end
      if (clr_mask) wmask <= '0;
    end
  end

  assign a_val = regs_q[a_idx];
  assign b_val = regs_q[b_idx];
  assign c_val = regs_q[c_idx];
endmodule

// File: rtl/rsx_stbuf.sv
module rsx_stbuf #(
  parameter int NST = 8,
  parameter int AW  = 8,
  parameter int DW  = 16,
  localparam int CW = $clog2(NST + 1),
  localparam int IW = $clog2(NST)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [AW-1:0] addr_q [NST];
  logic [DW-1:0] data_q [NST];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < NST; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else if (clr) begin
      cnt_q <= '0;
    end else if (push && !full) begin
      addr_q[cnt_q[IW-1:0]] <= push_addr;
      data_q[cnt_q[IW-1:0]] <= push_data;
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // later slots are younger, so the last match wins
  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int i = 0; i < NST; i++) begin
      if (CW'(i) < cnt_q && addr_q[i] == lk_addr) begin
        lk_hit  = 1'b1;
        lk_data = data_q[i];
      end
    end
  end

  assign full    = (cnt_q == CW'(NST));
  assign count   = cnt_q;
  assign rd_addr = addr_q[rd_idx];
  assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/rsx_undo.sv
module rsx_undo #(
  parameter int NUN = 8,
  parameter int AW  = 8,
  parameter int DW  = 16,
  localparam int CW = $clog2(NUN + 1),
  localparam int IW = $clog2(NUN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          log_en,
  input  logic [AW-1:0] log_addr,
  input  logic [DW-1:0] log_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count
);
  logic [AW-1:0] addr_q [NUN];
  logic [DW-1:0] data_q [NUN];
  logic [CW-1:0] cnt_q;
  logic          seen;

  always_comb begin
    seen = 1'b0;
    for (int i = 0; i < NUN; i++)
      if (CW'(i) < cnt_q && addr_q[i] == log_addr) seen = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < NUN; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else if (clr) begin
      cnt_q <= '0;
    end else if (log_en && !seen && cnt_q != CW'(NUN)) begin
      addr_q[cnt_q[IW-1:0]] <= log_addr;
      data_q[cnt_q[IW-1:0]] <= log_data;
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign count   = cnt_q;
  assign rd_addr = addr_q[rd_idx];
  assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/rsx_fprint.sv
module rsx_fprint #(
  parameter int NFP = 8,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] q_addr,
  output logic          q_hit
);
  logic [AW-1:0]  addr_q [NFP];
  logic [NFP-1:0] vld_q;
  logic [NFP-1:0] free;
  logic [NFP-1:0] grab;

  // one-hot pick of the lowest free slot
  assign free = ~vld_q;
  assign grab = free & (~free + NFP'(1));

  generate
    for (genvar g = 0; g < NFP; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[g]  <= 1'b0;
          addr_q[g] <= '0;
        end else if (clr) begin
          vld_q[g] <= 1'b0;
        end else if (ld_we && grab[g]) begin
          vld_q[g]  <= 1'b1;
          addr_q[g] <= ld_addr;
        end
      end
    end
  endgenerate

  always_comb begin
    q_hit = 1'b0;
    for (int i = 0; i < NFP; i++)
      if (vld_q[i] && addr_q[i] == q_addr) q_hit = 1'b1;
  end
endmodule

// File: rtl/rsx_replay_unit.sv
module rsx_replay_unit
  import rsx_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int NREG = 8,
  parameter int NST  = 8,
  parameter int NUN  = 8,
  parameter int NFP  = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          li_we,
  input  logic [RW-1:0] li_idx,
  input  logic [DW-1:0] li_val,
  input  logic          fp_we,
  input  logic [AW-1:0] fp_addr,
  input  logic          start,
  input  logic [DW-1:0] fix_val,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [2:0]    ins_op,
  input  logic [RW-1:0] ins_rd,
  input  logic [RW-1:0] ins_rs1,
  input  logic [RW-1:0] ins_rs2,
  input  logic [DW-1:0] ins_imm,
  input  logic [AW-1:0] ins_rec_addr,
  input  logic [DW-1:0] ins_rec_data,
  input  logic          ins_rec_taken,
  input  logic          ins_last,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic [RW-1:0] wb_idx,
  output logic [DW-1:0] wb_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  output logic          done,
  output logic          ok
);
  localparam int SCW = $clog2(NST + 1);
  localparam int UCW = $clog2(NUN + 1);
  localparam int SIW = $clog2(NST);
  localparam int UIW = $clog2(NUN);
  localparam int PW  = $clog2(NREG + NST + NUN + 1);

  st_e           st_q;
  logic [PW-1:0] ptr_q;
  logic [DW-1:0] fix_q;
  logic          fail_q, ok_q;

  op_e             op;
  logic            acc, begin_run, live, fail_nx;
  logic [DW-1:0]   a_val, b_val, c_val;
  logic [NREG-1:0] wmask;
  logic [AW-1:0]   ea;
  logic            lk_hit, st_full, in_rd;
  logic [DW-1:0]   lk_data, st_rdata, un_rdata;
  logic [AW-1:0]   st_raddr, un_raddr;
  logic [SCW-1:0]  st_cnt;
  logic [UCW-1:0]  un_cnt;
  logic            ex_we, ex_bad, st_push, un_log;
  logic [DW-1:0]   ex_val;
  logic [PW-1:0]   un_idx;
  logic            wb_left;
  logic [RW-1:0]   wb_cur;

  assign op        = op_e'(ins_op);
  assign ins_ready = (st_q == ST_RUN);
  assign acc       = ins_valid && ins_ready;
  assign begin_run = (st_q == ST_IDLE) && start;
  assign ea        = a_val[AW-1:0] + ins_imm[AW-1:0];
  assign wb_left   = ptr_q < PW'(NREG);
  assign wb_cur    = ptr_q[RW-1:0];
  assign un_idx    = PW'(un_cnt) - PW'(1) - ptr_q;

  // execute one slice entry and judge it against the initial run
  always_comb begin
    ex_we   = 1'b0;
    ex_val  = '0;
    ex_bad  = 1'b0;
    st_push = 1'b0;
    un_log  = 1'b0;
    case (op)
      OP_ADD:  begin ex_we = 1'b1; ex_val = a_val + b_val;   end
      OP_SUB:  begin ex_we = 1'b1; ex_val = a_val - b_val;   end
      OP_ADDI: begin ex_we = 1'b1; ex_val = a_val + ins_imm; end
      OP_SEED: begin ex_we = 1'b1; ex_val = fix_q;           end
      OP_LOAD: begin
        ex_we = 1'b1;
        if (lk_hit)                  ex_val = lk_data;
        else if (ea == ins_rec_addr) ex_val = ins_rec_data;
        else                         ex_bad = 1'b1;
      end
      OP_STORE: begin
        un_log = 1'b1;
        if (ea != ins_rec_addr && in_rd) ex_bad  = 1'b1;
        else if (st_full)                ex_bad  = 1'b1;
        else                             st_push = 1'b1;
      end
      OP_BRZ:  ex_bad = ((a_val == '0) != ins_rec_taken);
      default: ;
    endcase
  end

  assign live    = acc && !fail_q && !ex_bad;
  assign fail_nx = fail_q || ex_bad;

  rsx_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk, .rst_n,
    .clr_mask(begin_run),
    .li_we, .li_idx, .li_val,
    .ex_we(live && ex_we), .ex_idx(ins_rd), .ex_val,
    .a_idx(ins_rs1), .b_idx(ins_rs2), .c_idx(wb_cur),
    .a_val, .b_val, .c_val, .wmask
  );

  rsx_stbuf #(.NST(NST), .AW(AW), .DW(DW)) u_sb (
    .clk, .rst_n,
    .clr(begin_run),
    .push(live && st_push), .push_addr(ea), .push_data(b_val),
    .lk_addr(ea), .lk_hit, .lk_data,
    .rd_idx(ptr_q[SIW-1:0]), .rd_addr(st_raddr), .rd_data(st_rdata),
    .count(st_cnt), .full(st_full)
  );

  rsx_undo #(.NUN(NUN), .AW(AW), .DW(DW)) u_un (
    .clk, .rst_n,
    .clr(begin_run),
    .log_en(acc && un_log), .log_addr(ins_rec_addr), .log_data(ins_rec_data),
    .rd_idx(un_idx[UIW-1:0]), .rd_addr(un_raddr), .rd_data(un_rdata),
    .count(un_cnt)
  );

  rsx_fprint #(.NFP(NFP), .AW(AW)) u_fp (
    .clk, .rst_n,
    .clr(st_q == ST_DONE),
    .ld_we(fp_we), .ld_addr(fp_addr),
    .q_addr(ea), .q_hit(in_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      fix_q  <= '0;
      fail_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_RUN;
          fix_q  <= fix_val;
          fail_q <= 1'b0;
          ok_q   <= 1'b0;
        end
        ST_RUN: if (acc) begin
          fail_q <= fail_nx;
          if (ins_last) begin
            ptr_q <= '0;
            if (!fail_nx) begin
              ok_q <= 1'b1;
              st_q <= ST_WB;
            end else begin
              st_q <= ST_UNDO;
            end
          end
        end
        ST_WB: begin
          if (!wb_left) begin
            st_q  <= ST_MW;
            ptr_q <= '0;
          end else if (!wmask[wb_cur] || wb_ready) begin
            ptr_q <= ptr_q + PW'(1);
          end
        end
        ST_MW: begin
          if (ptr_q >= PW'(st_cnt))  st_q  <= ST_DONE;
          else if (mw_ready)         ptr_q <= ptr_q + PW'(1);
        end
        ST_UNDO: begin
          if (ptr_q >= PW'(un_cnt))  st_q  <= ST_DONE;
          else if (mw_ready)         ptr_q <= ptr_q + PW'(1);
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wb_valid = (st_q == ST_WB) && wb_left && wmask[wb_cur];
  assign wb_idx   = wb_cur;
  assign wb_data  = c_val;
  assign mw_valid = ((st_q == ST_MW)   && ptr_q < PW'(st_cnt)) ||
                    ((st_q == ST_UNDO) && ptr_q < PW'(un_cnt));
  assign mw_addr  = (st_q == ST_UNDO) ? un_raddr : st_raddr;
  assign mw_data  = (st_q == ST_UNDO) ? un_rdata : st_rdata;
  assign done     = (st_q == ST_DONE);
  assign ok       = ok_q;
endmodule

// File: rtl/rsx_replay_chk.sv
module rsx_replay_chk #(
  parameter int RW = 3,
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ins_ready,
  input logic          wb_valid,
  input logic          wb_ready,
  input logic [RW-1:0] wb_idx,
  input logic [DW-1:0] wb_data,
  input logic          mw_valid,
  input logic          mw_ready,
  input logic [AW-1:0] mw_addr,
  input logic [DW-1:0] mw_data,
  input logic          done,
  input logic          ok
);
  p_wb_needs_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ok);

  p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_idx) && $stable(wb_data));

  p_mw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ok_falls_on_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ok) |-> $past(start));

  p_stream_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> !wb_valid && !mw_valid);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wb_valid && !mw_valid && !ins_ready);
endmodule

bind rsx_replay_unit rsx_replay_chk #(.RW(RW), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ins_ready(ins_ready),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_idx(wb_idx), .wb_data(wb_data),
  .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
  .done(done), .ok(ok)
);

// File: tb/rsx_replay_unit_tb.sv
module rsx_replay_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic li_we = 0, fp_we = 0, start = 0;
  logic [2:0] li_idx = 0;
  logic [15:0] li_val = 0, fix_val = 0;
  logic [7:0] fp_addr = 0;
  logic ins_valid = 0, ins_rec_taken = 0, ins_last = 0;
  logic ins_ready;
  logic [2:0] ins_op = 0, ins_rd = 0, ins_rs1 = 0, ins_rs2 = 0;
  logic [15:0] ins_imm = 0, ins_rec_data = 0;
  logic [7:0] ins_rec_addr = 0;
  logic wb_valid, mw_valid, done, ok;
  logic wb_ready, mw_ready;
  logic [2:0] wb_idx;
  logic [15:0] wb_data, mw_data;
  logic [7:0] mw_addr;

  rsx_replay_unit u_dut (.*);

  typedef struct packed {
    logic [2:0] scn; logic [2:0] op; logic [2:0] rd; logic [2:0] rs1; logic [2:0] rs2;
    logic [15:0] imm; logic [7:0] ra; logic [15:0] rdat; logic rt; logic last;
  } vec_t;
  typedef struct packed { logic [2:0] scn; logic [7:0] key; logic [15:0] val; } exp_t;

  // op: 0 add 1 sub 2 addi 3 seed 4 load 5 store 6 brz
  localparam vec_t VEC [24] = '{
    '{3'd0,3'd3,3'd1,3'd0,3'd0,16'h0000,8'h00,16'h0000,1'b0,1'b0},
    '{3'd0,3'd2,3'd2,3'd1,3'd0,16'h0003,8'h00,16'h0000,1'b0,1'b0},
    '{3'd0,3'd5,3'd0,3'd3,3'd2,16'h0000,8'h30,16'hAAAA,1'b0,1'b0},
    '{3'd0,3'd6,3'd0,3'd0,3'd0,16'h0000,8'h00,16'h0000,1'b1,1'b1},
    '{3'd1,3'd3,3'd5,3'd0,3'd0,16'h0000,8'h00,16'h0000,1'b0,1'b0},
    '{3'd1,3'd5,3'd0,3'd4,3'd5,16'h0000,8'h40,16'h1111,1'b0,1'b0},
    '{3'd1,3'd6,3'd0,3'd5,3'd0,16'h0000,8'h00,16'h0000,1'b1,1'b0},
    '{3'd1,3'd5,3'd0,3'd6,3'd0,16'h0000,8'h60,16'h2222,1'b0,1'b1},
    '{3'd2,3'd3,3'd1,3'd0,3'd0,16'h0000,8'h00,16'h0000,1'b0,1'b0},
    '{3'd2,3'd5,3'd0,3'd1,3'd2,16'h0000,8'h10,16'h3333,1'b0,1'b1},
    '{3'd3,3'd3,3'd1,3'd0,3'd0,16'h0000,8'h00,16'h0000,1'b0,1'b0},
    '{3'd3,3'd4,3'd2,3'd1,3'd0,16'h0000,8'h50,16'h0007,1'b0,1'b1},
    '{3'd4,3'd3,3'd1,3'd0,3'd0,16'h0000,8'h00,16'h0000,1'b0,1'b0},
    '{3'd4,3'd5,3'd0,3'd1,3'd7,16'h0000,8'h58,16'h4444,1'b0,1'b0},
    '{3'd4,3'd5,3'd0,3'd1,3'd6,16'h0000,8'h58,16'h5555,1'b0,1'b0},
    '{3'd4,3'd4,3'd3,3'd1,3'd0,16'h0000,8'h50,16'h9999,1'b0,1'b0},
    '{3'd4,3'd1,3'd4,3'd3,3'd2,16'h0000,8'h00,16'h0000,1'b0,1'b1},
    '{3'd5,3'd3,3'd1,3'd0,3'd0,16'h0000,8'h00,16'h0000,1'b0,1'b0},
    '{3'd5,3'd5,3'd0,3'd2,3'd1,16'h0000,8'h20,16'hBEEF,1'b0,1'b0},
    '{3'd5,3'd5,3'd0,3'd2,3'd1,16'h0000,8'h20,16'hCAFE,1'b0,1'b0},
    '{3'd5,3'd6,3'd0,3'd1,3'd0,16'h0000,8'h00,16'h0000,1'b1,1'b1},
    '{3'd6,3'd3,3'd6,3'd0,3'd0,16'h0000,8'h00,16'h0000,1'b0,1'b0},
    '{3'd6,3'd4,3'd7,3'd6,3'd0,16'h003E,8'h40,16'h1234,1'b0,1'b0},
    '{3'd6,3'd0,3'd5,3'd7,3'd6,16'h0000,8'h00,16'h0000,1'b0,1'b1}
  };
  localparam logic [15:0] FIX [7] = '{16'h8, 16'h5, 16'h20, 16'h30, 16'h50, 16'h1, 16'h2};
  localparam logic        XOK [7] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam exp_t XWB [8] = '{
    '{3'd0,8'd1,16'h0008}, '{3'd0,8'd2,16'h000B},
    '{3'd4,8'd1,16'h0050}, '{3'd4,8'd3,16'h0060}, '{3'd4,8'd4,16'h0040},
    '{3'd6,8'd5,16'h1236}, '{3'd6,8'd6,16'h0002}, '{3'd6,8'd7,16'h1234}};
  localparam exp_t XMW [7] = '{
    '{3'd0,8'h30,16'h000B},
    '{3'd1,8'h60,16'h2222}, '{3'd1,8'h40,16'h1111},
    '{3'd2,8'h10,16'h3333},
    '{3'd4,8'h50,16'h0070}, '{3'd4,8'h50,16'h0060},
    '{3'd5,8'h20,16'hBEEF}};

  int tests = 0, fails = 0, cyc = 0;
  int nwb = 0, nmw = 0, ndone = 0, ok_bad = 0, hold_bad = 0, dlen = 0, dmax = 0;
  logic [7:0]  cw_key [16]; logic [15:0] cw_val [16];
  logic [7:0]  cm_key [16]; logic [15:0] cm_val [16];
  logic        ok_done = 0, bp = 0, tog = 0, pend = 0;
  logic [7:0]  pk; logic [15:0] pv;

  assign wb_ready = bp ? tog : 1'b1;
  assign mw_ready = bp ? tog : 1'b1;
  always @(negedge clk) tog <= ~tog;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pend && !(wb_valid && {5'd0, wb_idx} == pk && wb_data == pv)) hold_bad <= hold_bad + 1;
    pend <= wb_valid && !wb_ready;
    pk <= {5'd0, wb_idx}; pv <= wb_data;
    if (wb_valid && !ok) ok_bad <= ok_bad + 1;
    if (wb_valid && wb_ready && nwb < 16) begin
      cw_key[nwb] <= {5'd0, wb_idx}; cw_val[nwb] <= wb_data; nwb <= nwb + 1;
    end
    if (mw_valid && mw_ready && nmw < 16) begin
      cm_key[nmw] <= mw_addr; cm_val[nmw] <= mw_data; nmw <= nmw + 1;
    end
    if (done) begin ndone <= ndone + 1; ok_done <= ok; dlen <= dlen + 1; end
    else dlen <= 0;
    if (dlen > dmax) dmax <= dlen;
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int s);
    case (s)
      0: return "R2"; 1: return "R3"; 2: return "R5"; 3: return "R4";
      4: return "R4"; 5: return "R6"; default: return "R2";
    endcase
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic run_scn(input int s);
    int xw, xm, d0;
    for (int i = 0; i < 8; i++) begin
      li_we = 1; li_idx = 3'(i); li_val = 16'(16 * i); @(negedge clk);
    end
    li_we = 0;
    fp_we = 1; fp_addr = 8'h20; @(negedge clk);
    fp_addr = 8'h40; @(negedge clk);
    fp_we = 0;
    nwb = 0; nmw = 0; d0 = ndone;
    start = 1; fix_val = FIX[s]; @(negedge clk);
    start = 0;
    for (int k = 0; k < 24; k++) begin
      if (int'(VEC[k].scn) == s) begin
        ins_valid = 1; ins_op = VEC[k].op; ins_rd = VEC[k].rd; ins_rs1 = VEC[k].rs1;
        ins_rs2 = VEC[k].rs2; ins_imm = VEC[k].imm; ins_rec_addr = VEC[k].ra;
        ins_rec_data = VEC[k].rdat; ins_rec_taken = VEC[k].rt; ins_last = VEC[k].last;
        while (!ins_ready) @(negedge clk);
        @(negedge clk);
      end
    end
    ins_valid = 0; ins_last = 0;
    for (int t = 0; t < 500 && ndone == d0; t++) @(negedge clk);
    check("R10", "done after stream", ndone - d0, 1);
    check(tag_of(s), XOK[s] ? "ok on success R7" : "ok on squash R8", int'(ok_done), int'(XOK[s]));
    xw = 0;
    for (int e = 0; e < 8; e++) if (int'(XWB[e].scn) == s) begin
      if (xw < nwb) begin
        check("R7", "wb idx", int'(cw_key[xw]), int'(XWB[e].key));
        check(tag_of(s), "wb value", int'(cw_val[xw]), int'(XWB[e].val));
      end
      xw++;
    end
    check(XOK[s] ? "R7" : "R8", "wb count", nwb, xw);
    xm = 0;
    for (int e = 0; e < 7; e++) if (int'(XMW[e].scn) == s) begin
      if (xm < nmw) begin
        check(XOK[s] ? "R7" : "R6", "mw addr", int'(cm_key[xm]), int'(XMW[e].key));
        check(XOK[s] ? "R7" : "R8", "mw data", int'(cm_val[xm]), int'(XMW[e].val));
      end
      xm++;
    end
    check(XOK[s] ? "R7" : "R8", "mw count", nmw, xm);
  endtask

  initial begin
    wait (cyc > 50000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle outputs straight after reset
    check("R1", "ins_ready", int'(ins_ready), 0);
    check("R1", "wb_valid", int'(wb_valid), 0);
    check("R1", "mw_valid", int'(mw_valid), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "ok", int'(ok), 0);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 7; s++) run_scn(s);
    // R9: same merges under stalled ready
    bp = 1;
    run_scn(4);
    run_scn(1);
    bp = 0;
    check("R9", "payload held while stalled", hold_bad, 0);
    check("R9", "write-back seen without ok", ok_bad, 0);
    check("R11", "done pulse width", dmax, 1);
    check("R11", "ok held after done", int'(ok), int'(XOK[1]));
    finish_run();
  end
endmodule